// File: doc/BRIEF.md
# Line Test Pattern Generator

This block produces the serial bit stream sent toward a T1/E1 line. A 3-bit source select chooses what goes out on each bit clock: the user transmit bit, constant ones, a loop-up code repeated back to back, a loop-down code repeated back to back, or a quasi-random sequence. The quasi-random sequence may be inverted, and it may carry single-bit errors on request. A mode input chooses between the T1 sequence, which is 2^20-1 long with a run of zeros capped at 14, and the E1 sequence, which is 2^15-1 long.

While the loop-up code is being sent, the block raises a flag. Downstream logic uses this flag to stop automatic loop-code detection and remote loopback from reacting to the far end's answer. The stream runs at one bit per clock and has no back-pressure: every clock moves exactly one bit, so the interface has no valid/ready pair. The select, mode and strobe are plain control pins.

Top module: `line_test_patgen`

## Requirements
- R1: With select 000, `line_bit` equals `tx_data` as sampled at the previous rising clock edge.
- R2: With select 001, `line_bit` is 1 on every clock.
- R3: With select 010, `line_bit` repeats the 5-bit sequence 0,0,0,0,1. The first bit goes out on the clock after the select changes to 010.
- R4: With select 011, `line_bit` repeats the 3-bit sequence 0,0,1. The first bit goes out on the clock after the select changes to 011.
- R5: With select 1xx and `e1_mode`=0, the raw bit comes from a 20-bit register s, seeded all ones. On each clock the new bit is b = s[19]^s[16], the register shifts to {s[18:0],b}, and b is the raw bit. This is the x^20+x^17+1 recurrence.
- R6: In T1 quasi-random mode, a raw bit that follows 14 consecutive zero bits is forced to 1. The uninverted, error-free stream therefore never holds more than 14 zeros in a row.
- R7: With select 1xx and `e1_mode`=1, the raw bit comes from a 15-bit register seeded all ones. The new bit is b = s[14]^s[13], and the register shifts in b. If the register is ever all zero, it reloads the seed.
- R8: Select 101 and select 111 send the complement of the quasi-random bit. Select 100 and select 110 send it unchanged.
- R9: With select 110 or 111, each 0-to-1 transition of `err_strobe` flips exactly one output bit. That bit is the one registered at the edge where the strobe is first seen high. Under any other select, strobe transitions have no effect on `line_bit`.
- R10: `loop_det_inhibit` is 1 on the clock after an edge that saw select 010. On every other clock it is 0.
- R11: During reset, `line_bit` and `loop_det_inhibit` are 0. Both pseudo-random registers hold their seeds, and the block passes data as if the select were 000.
- R12: Both pseudo-random registers advance only on clocks where select bit 2 is 1. They hold otherwise, so leaving quasi-random mode and returning resumes the sequence where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_sel | input | 3 | Source select code (see R1 to R9) |
| e1_mode | input | 1 | 0 selects the T1 sequence, 1 selects the E1 sequence |
| err_strobe | input | 1 | Error insert request; acts on its rising transition |
| tx_data | input | 1 | User transmit bit |
| line_bit | output | 1 | Registered serial line bit |
| loop_det_inhibit | output | 1 | Registered flag, high while the loop-up code is sent |

## Verification
Every result is due exactly one clock after the edge that samples its inputs: the line bit, the inhibit flag, the start of a loop code after a select change, and an inserted error. The bench therefore sets the inputs just after a rising edge and works out the expected bit from an arithmetic model of the recurrences and code positions. It then waits for the next rising edge and samples 1 ns later. Sweeps cover every select code in both modes, with strobe pulses, select changes in the middle of a code, and a long T1 run whose longest run of zeros is measured.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;
  typedef enum logic [2:0] {
    SRC_DATA       = 3'b000,
    SRC_ONES       = 3'b001,
    SRC_LOOP_UP    = 3'b010,
    SRC_LOOP_DOWN  = 3'b011,
    SRC_PR         = 3'b100,
    SRC_PR_INV     = 3'b101,
    SRC_PR_ERR     = 3'b110,
    SRC_PR_INV_ERR = 3'b111
  } src_e;

  localparam int T1_LEN     = 20;
  localparam int T1_TAP     = 17;
  localparam int E1_LEN     = 15;
  localparam int E1_TAP     = 14;
  localparam int ZERO_LIMIT = 14;
  localparam int UP_LEN     = 5;
  localparam int DOWN_LEN   = 3;
  // codes listed first-sent bit at the MSB
  localparam logic [UP_LEN-1:0]   UP_CODE   = 5'b00001;
  localparam logic [DOWN_LEN-1:0] DOWN_CODE = 3'b001;
endpackage

// File: rtl/ltpg_lfsr.sv
module ltpg_lfsr #(
  parameter int LEN = 20,
  parameter int TAP = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic new_bit
);
  localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

  logic [LEN-1:0] state;

  assign new_bit = state[LEN-1] ^ state[TAP-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (adv) begin
      if (state == '0) state <= SEED;
      else             state <= {state[LEN-2:0], new_bit};
    end
  end

  // R12: register holds while not advancing
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
  // R7: seeded register never sits at all zero after an advance
  a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> state != '0);
endmodule

// File: rtl/ltpg_zero_limit.sv
module ltpg_zero_limit #(
  parameter int LIMIT = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic raw,
  output logic limited
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] zrun;
  logic          at_cap;

  assign at_cap  = (zrun == CW'(LIMIT));
  assign limited = active ? (raw | at_cap) : raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        zrun <= '0;
    else if (!active)  zrun <= '0;
    else if (limited)  zrun <= '0;
    else               zrun <= zrun + 1'b1;
  end

  a_r6_zero_cap: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= CW'(LIMIT));
  a_r6_forced_one: assert property (@(posedge clk) disable iff (!rst_n)
    (active && at_cap) |-> limited);
endmodule

// File: rtl/ltpg_loop_code.sv
module ltpg_loop_code #(
  parameter int                  UP_LEN    = 5,
  parameter int                  DOWN_LEN  = 3,
  parameter logic [UP_LEN-1:0]   UP_CODE   = 5'b00001,
  parameter logic [DOWN_LEN-1:0] DOWN_CODE = 3'b001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic down,
  input  logic restart,
  output logic code_bit
);
  localparam int MAXL = (UP_LEN > DOWN_LEN) ? UP_LEN : DOWN_LEN;
  localparam int PW   = (MAXL > 1) ? $clog2(MAXL) : 1;
  localparam int VW   = 2 ** PW;

  localparam logic [VW-1:0] UP_V   = VW'(UP_CODE);
  localparam logic [VW-1:0] DOWN_V = VW'(DOWN_CODE);

  logic [PW-1:0] pos, cur, last, idx, nxt;

  always_comb begin
    cur  = restart ? '0 : pos;
    last = down ? PW'(DOWN_LEN - 1) : PW'(UP_LEN - 1);
    idx  = last - cur;
    code_bit = down ? DOWN_V[idx] : UP_V[idx];
    nxt  = (cur == last) ? '0 : cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos <= '0;
    else if (!en) pos <= '0;
    else          pos <= nxt;
  end

  a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && !restart) |-> pos < PW'(UP_LEN));
  a_r4_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (en && down && !restart) |-> pos < PW'(DOWN_LEN));
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart) |=> pos == PW'(1));
endmodule

// File: rtl/ltpg_err_insert.sv
module ltpg_err_insert (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic enable,
  output logic flip
);
  logic strobe_q;

  assign flip = strobe & ~strobe_q & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> !flip);
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !flip);
endmodule

// File: rtl/line_test_patgen.sv
module line_test_patgen
  import ltpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] test_sel,
  input  logic       e1_mode,
  input  logic       err_strobe,
  input  logic       tx_data,
  output logic       line_bit,
  output logic       loop_det_inhibit
);
  src_e sel, sel_q;
  logic t1_bit, e1_bit, pr_raw, pr_lim, pr_out;
  logic pr_on, t1_active, loop_on, restart, code_bit, flip;
  logic base_bit, next_bit;

  assign sel       = src_e'(test_sel);
  assign pr_on     = test_sel[2];
  assign t1_active = pr_on & ~e1_mode;
  assign loop_on   = (sel == SRC_LOOP_UP) || (sel == SRC_LOOP_DOWN);
  assign restart   = (sel != sel_q);

  ltpg_lfsr #(.LEN(T1_LEN), .TAP(T1_TAP)) u_t1 (
    .clk(clk), .rst_n(rst_n), .adv(pr_on), .new_bit(t1_bit));

  ltpg_lfsr #(.LEN(E1_LEN), .TAP(E1_TAP)) u_e1 (
    .clk(clk), .rst_n(rst_n), .adv(pr_on), .new_bit(e1_bit));

  assign pr_raw = e1_mode ? e1_bit : t1_bit;

  ltpg_zero_limit #(.LIMIT(ZERO_LIMIT)) u_zl (
    .clk(clk), .rst_n(rst_n), .active(t1_active), .raw(pr_raw), .limited(pr_lim));

  ltpg_loop_code #(
    .UP_LEN(UP_LEN), .DOWN_LEN(DOWN_LEN), .UP_CODE(UP_CODE), .DOWN_CODE(DOWN_CODE)
  ) u_lc (
    .clk(clk), .rst_n(rst_n), .en(loop_on), .down(test_sel[0]),
    .restart(restart), .code_bit(code_bit));

  ltpg_err_insert u_ei (
    .clk(clk), .rst_n(rst_n), .strobe(err_strobe),
    .enable(test_sel[2] & test_sel[1]), .flip(flip));

  assign pr_out = pr_lim ^ test_sel[0];

  always_comb begin
    unique case (sel)
      SRC_DATA:      base_bit = tx_data;
      SRC_ONES:      base_bit = 1'b1;
      SRC_LOOP_UP,
      SRC_LOOP_DOWN: base_bit = code_bit;
      default:       base_bit = pr_out;
    endcase
    next_bit = base_bit ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_bit         <= 1'b0;
      loop_det_inhibit <= 1'b0;
      sel_q            <= SRC_DATA;
    end else begin
      line_bit         <= next_bit;
      loop_det_inhibit <= (sel == SRC_LOOP_UP);
      sel_q            <= sel;
    end
  end

  a_r1_data: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_DATA) |=> line_bit == $past(tx_data));
  a_r2_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_ONES) |=> line_bit);
  a_r10_inhibit_on: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_LOOP_UP) |=> loop_det_inhibit);
  a_r10_inhibit_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SRC_LOOP_UP) |=> !loop_det_inhibit);
  a_r3_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && restart) |=> !line_bit);
endmodule

// File: tb/line_test_patgen_test.sv
module line_test_patgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] test_sel = 3'b000;
  logic       e1_mode = 1'b0;
  logic       err_strobe = 1'b0;
  logic       tx_data = 1'b0;
  logic       line_bit, loop_det_inhibit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [19:0] m20 = '1;
  logic [14:0] m15 = '1;
  int          mz = 0;
  int          mpos = 0;
  logic [2:0]  msel_q = 3'b000;
  logic        mst_q = 1'b0;
  int          zrun = 0;
  int          zmax = 0;

  line_test_patgen uut (
    .clk(clk), .rst_n(rst_n), .test_sel(test_sel), .e1_mode(e1_mode),
    .err_strobe(err_strobe), .tx_data(tx_data),
    .line_bit(line_bit), .loop_det_inhibit(loop_det_inhibit));

  always #5 clk = ~clk;

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] s, logic m);
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return m ? "R7" : "R5";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic tick(logic [2:0] s, logic m, logic st, logic d, string tag);
    logic t1b, e1b, raw, act, lim, rs, base, flp, expb;
    int cur, len;
    test_sel = s; e1_mode = m; err_strobe = st; tx_data = d;
    t1b = m20[19] ^ m20[16];
    e1b = m15[14] ^ m15[13];
    raw = m ? e1b : t1b;
    act = s[2] & ~m;
    lim = act ? (raw | (mz == 14)) : raw;
    rs  = (s != msel_q);
    cur = rs ? 0 : mpos;
    len = (s == 3'd3) ? 3 : 5;
    case (s)
      3'd0: base = d;
      3'd1: base = 1'b1;
      3'd2: base = (cur == 4);
      3'd3: base = (cur == 2);
      default: base = lim ^ s[0];
    endcase
    flp  = st & ~mst_q & s[2] & s[1];
    expb = base ^ flp;
    if (s[2]) begin
      m20 = {m20[18:0], t1b};
      m15 = {m15[13:0], e1b};
    end
    mz = act ? (lim ? 0 : mz + 1) : 0;
    if (s == 3'd2 || s == 3'd3) mpos = (cur + 1 == len) ? 0 : cur + 1;
    else mpos = 0;
    msel_q = s;
    mst_q = st;
    @(posedge clk);
    #1;
    check(tag, line_bit, expb, "line_bit");
    check("R10", loop_det_inhibit, (s == 3'd2), "loop_det_inhibit");
    if (s == 3'd4 && !m) begin
      zrun = line_bit ? 0 : zrun + 1;
      if (zrun > zmax) zmax = zrun;
    end else begin
      zrun = 0;
    end
  endtask

  initial begin
    #1;
    // R11: reset values
    repeat (3) @(posedge clk);
    #1;
    check("R11", line_bit, 1'b0, "line_bit in reset");
    check("R11", loop_det_inhibit, 1'b0, "inhibit in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R11: passes data right after reset
    tick(3'd0, 1'b0, 1'b0, 1'b1, "R11");
    tick(3'd0, 1'b0, 1'b0, 1'b0, "R11");

    // sweep every select in both modes, with strobe pulses and data patterns
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 8; s++) begin
        for (int i = 0; i < 40; i++) begin
          tick(3'(s), 1'(m), ((i % 5) < 2), 1'(((i * 7) >> 2) ^ i), tag_of(3'(s), 1'(m)));
        end
      end
    end

    // loop codes restarted mid-sequence by a select change
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < k + 2; i++) tick(3'd2, 1'b0, 1'b0, 1'b0, "R3");
      for (int i = 0; i < k + 1; i++) tick(3'd3, 1'b0, 1'b0, 1'b1, "R4");
    end

    // strobe ignored outside error codes (R9), held high across many clocks
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < 12; i++) tick(3'(s), 1'b0, (i % 3 == 0), 1'b1, "R9");
    end
    for (int i = 0; i < 12; i++) tick(3'd7, 1'b1, (i > 2), 1'b0, "R9");

    // R12: leave the sequence and return
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 25; i++) tick(3'd4, 1'(r & 1), 1'b0, 1'b0, "R12");
      for (int i = 0; i < 9; i++)  tick(3'd1, 1'(r & 1), 1'b0, 1'b0, "R12");
    end

    // long T1 run for the zero cap
    zrun = 0;
    for (int i = 0; i < 120000; i++) tick(3'd4, 1'b0, 1'b0, 1'b0, "R5");
    checks++;
    if (zmax > 14) begin
      errors++;
      $display("FAIL R6 longest zero run: actual=%0d expected<=%0d", zmax, 14);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule